// File: doc/BRIEF.md
# Key-Locked Control Register Bank

This block holds a window of 32-bit control words behind a plain word-oriented read/write port. The window spans 4 KB of byte addresses (1024 words); only the word index `bus_addr[11:2]` is decoded. Each word is read-write, read-only, write-only or unmapped. Any access that breaks its word's class produces a one-cycle error pulse. An illegal write never changes stored state.

A key-operated lock guards the bank. It comes out of reset closed. Writing the open key to the unlock word opens it, and writing the close key to the lock word closes it. While the bank is closed, writes to ordinary words are refused with an error. The scratch bit at offset 0x000 and the two key words are still accepted.

One bit of the reset-control word raises a single-cycle system reset request. A short list of words come out of reset with fixed values.

Top module: `keyreg_bank`

## Requirements
- R1: After reset the bank is locked, and a read of the status word at 0x00C returns 1 in bit 0 with all other bits 0. Words 0x100, 0x104 and 0x108 read 0x0001A008. 0x10C reads 0x0000003F. 0x154 reads 0x00003F03. 0x25C reads BOOT_VAL (default 0x00000001). 0x530 reads ID_CODE (default 0x1A5C0093). Every other word reads 0.
- R2: A write to 0x008 whose data bits [15:0] equal 0xDF0D unlocks the bank. A write to 0x008 with any other value leaves the lock state as it was. Writes to 0x008 never raise an error.
- R3: A write to 0x004 whose data bits [15:0] equal 0x767B locks the bank. A write to 0x004 with any other value leaves the lock state as it was. Writes to 0x004 never raise an error.
- R4: While the bank is locked, a write to any read-write word other than 0x000 is dropped and raises an error. A write to 0x000 while locked is accepted without error.
- R5: The word at 0x000 keeps only bit 0 of the written data and reads 0 in bits [31:1].
- R6: The read-only words 0x00C, 0x10C, 0x25C and 0x530 ignore writes and flag each write as an error. A read of a write-only word (0x004, 0x008, 0x60C, 0x614) returns the stored word and flags an error. The start-trigger words 0x60C and 0x614 store written data when the bank is unlocked.
- R7: A write to an unmapped word is ignored and flagged. A read of an unmapped word returns its stored value (0) and is flagged.
- R8: Read data appears on `bus_rdata` on the cycle after the read is presented and holds until the next read. `acc_err` is high for exactly that one following cycle per offending access, and is low otherwise.
- R9: A write of 1 in bit 0 to 0x200 while the bank is unlocked raises `rst_req` for one cycle after the write. The stored bit reads back as written, and a write of 0 raises no request.
- R10: The read-write words are 0x000, 0x100–0x108, 0x110–0x16C, 0x200–0x240 and 0x700–0x7D4. All offsets not listed in R6 or here are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (12) | Byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| acc_err | output | 1 | One-cycle pulse for an illegal access |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situations to reach are the interleavings of lock state with access class. Examples are an ordinary write refused while locked, followed later by the same write accepted after unlocking. Another is a near-miss key that must leave the lock untouched. The stimulus combines a directed walk through each key and class case with a long random mix. That mix sends correct keys about one op in ten, so the bank flips many times between locked and unlocked. A bench model of the storage and lock predicts every read value, error pulse and reset request.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  localparam logic [15:0] KEY_OPEN  = 16'hDF0D;
  localparam logic [15:0] KEY_CLOSE = 16'h767B;

  // word indices (byte offset / 4)
  localparam int unsigned W_SCRATCH = 'h000;
  localparam int unsigned W_CLOSE   = 'h001;
  localparam int unsigned W_OPEN    = 'h002;
  localparam int unsigned W_STATUS  = 'h003;
  localparam int unsigned W_PLL_LO  = 'h040;
  localparam int unsigned W_PLL_HI  = 'h042;
  localparam int unsigned W_PLLSTS  = 'h043;
  localparam int unsigned W_CFG_LO  = 'h044;
  localparam int unsigned W_CFG_HI  = 'h05B;
  localparam int unsigned W_UARTCK  = 'h055;
  localparam int unsigned W_RST_LO  = 'h080;
  localparam int unsigned W_SRST    = 'h080;
  localparam int unsigned W_RST_HI  = 'h090;
  localparam int unsigned W_BOOT    = 'h097;
  localparam int unsigned W_IDCODE  = 'h14C;
  localparam int unsigned W_TRIG0   = 'h183;
  localparam int unsigned W_TRIG1   = 'h185;
  localparam int unsigned W_PIN_LO  = 'h1C0;
  localparam int unsigned W_PIN_HI  = 'h1F5;

  function automatic acc_e classify(int unsigned w);
    if (w == W_STATUS || w == W_PLLSTS || w == W_BOOT || w == W_IDCODE)
      return ACC_RO;
    if (w == W_CLOSE || w == W_OPEN || w == W_TRIG0 || w == W_TRIG1)
      return ACC_WO;
    if (w == W_SCRATCH ||
        (w >= W_PLL_LO && w <= W_PLL_HI) ||
        (w >= W_CFG_LO && w <= W_CFG_HI) ||
        (w >= W_RST_LO && w <= W_RST_HI) ||
        (w >= W_PIN_LO && w <= W_PIN_HI))
      return ACC_RW;
    return ACC_NONE;
  endfunction

  function automatic logic [31:0] reset_word(int unsigned w, logic [31:0] id_code,
                                             logic [31:0] boot_val);
    if (w >= W_PLL_LO && w <= W_PLL_HI) return 32'h0001_A008;
    if (w == W_PLLSTS) return 32'h0000_003F;
    if (w == W_UARTCK) return 32'h0000_3F03;
    if (w == W_BOOT)   return boot_val;
    if (w == W_IDCODE) return id_code;
    return 32'h0;
  endfunction

endpackage

// File: rtl/keyreg_decode.sv
module keyreg_decode
  import keyreg_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  output acc_e             cls
);
  always_comb begin
    cls = classify(int'(idx));
  end
endmodule

// File: rtl/keyreg_lock.sv
module keyreg_lock
  import keyreg_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_key,
  output logic             locked
);
  logic locked_q, locked_d;
  logic hit_open, hit_close;

  always_comb begin
    hit_open  = wr_en && (int'(wr_idx) == W_OPEN)  && (wr_key == KEY_OPEN);
    hit_close = wr_en && (int'(wr_idx) == W_CLOSE) && (wr_key == KEY_CLOSE);
    locked_d  = locked_q;
    if (hit_open)  locked_d = 1'b0;
    if (hit_close) locked_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b1;
    else        locked_q <= locked_d;
  end

  assign locked = locked_q;

  // R2: correct open key opens the bank
  p_open_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) == W_OPEN && wr_key == KEY_OPEN) |=> !locked);
  // R3: correct close key closes the bank
  p_close_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) == W_CLOSE && wr_key == KEY_CLOSE) |=> locked);
  // R2/R3: without a key write the lock state holds
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (int'(wr_idx) == W_OPEN || int'(wr_idx) == W_CLOSE)) |=> $stable(locked));
endmodule

// File: rtl/keyreg_store.sv
module keyreg_store
  import keyreg_pkg::*;
#(
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] ID_CODE  = 32'h1A5C_0093,
  parameter logic [31:0] BOOT_VAL = 32'h0000_0001,
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [31:0] RST_V = reset_word(i, ID_CODE, BOOT_VAL);
    logic hit;
    assign hit = we && (int'(widx) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[i] <= RST_V[DATA_W-1:0];
      else if (hit) mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[ridx];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/keyreg_bank.sv
module keyreg_bank
  import keyreg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] ID_CODE  = 32'h1A5C_0093,
  parameter logic [31:0] BOOT_VAL = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              acc_err,
  output logic              rst_req
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  idx;
  acc_e              cls;
  logic              locked;
  logic              key_addr, wr_bad, rd_bad, st_we, srst_d;
  logic [DATA_W-1:0] st_wd, st_rdata;
  logic              err_q, srst_q, stsel_q, stval_q;
  logic              stsel_d, stval_d;

  assign idx = bus_addr[ADDR_W-1:2];

  keyreg_decode #(.IDX_W(IDX_W)) u_decode (
    .idx (idx),
    .cls (cls)
  );

  keyreg_lock #(.IDX_W(IDX_W)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .wr_idx (idx),
    .wr_key (bus_wdata[15:0]),
    .locked (locked)
  );

  always_comb begin
    key_addr = (int'(idx) == W_CLOSE) || (int'(idx) == W_OPEN);
    wr_bad   = bus_wr && ((cls == ACC_NONE) || (cls == ACC_RO) ||
               (locked && (int'(idx) != W_SCRATCH) && !key_addr));
    rd_bad   = bus_rd && ((cls == ACC_NONE) || (cls == ACC_WO));
    st_we    = bus_wr && !wr_bad && !key_addr;
    st_wd    = (int'(idx) == W_SCRATCH) ? DATA_W'(bus_wdata[0]) : bus_wdata;
    srst_d   = st_we && (int'(idx) == W_SRST) && bus_wdata[0];
    stsel_d  = bus_rd ? (int'(idx) == W_STATUS) : stsel_q;
    stval_d  = bus_rd ? locked : stval_q;
  end

  keyreg_store #(
    .DEPTH    (DEPTH),
    .DATA_W   (DATA_W),
    .ID_CODE  (ID_CODE),
    .BOOT_VAL (BOOT_VAL)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .widx  (idx),
    .wdata (st_wd),
    .re    (bus_rd),
    .ridx  (idx),
    .rdata (st_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      srst_q  <= 1'b0;
      stsel_q <= 1'b0;
      stval_q <= 1'b0;
    end else begin
      err_q   <= wr_bad || rd_bad;
      srst_q  <= srst_d;
      stsel_q <= stsel_d;
      stval_q <= stval_d;
    end
  end

  assign bus_rdata = stsel_q ? DATA_W'(stval_q) : st_rdata;
  assign acc_err   = err_q;
  assign rst_req   = srst_q;

  // R8: an error pulse always follows an access
  p_err_after_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(bus_rd || bus_wr));
  // R4: ordinary write while locked is flagged
  p_locked_write_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && locked && cls == ACC_RW && int'(idx) != W_SCRATCH) |=> acc_err);
  // R9: reset request only follows an unlocked write
  p_srst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(bus_wr && !locked));
  // R6: read-only write flagged
  p_ro_write_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cls == ACC_RO) |=> (acc_err && !rst_req));
endmodule

// File: tb/keyreg_bank_tb_top.sv
module keyreg_bank_tb_top;
  localparam logic [31:0] ID_V   = 32'h1A5C_0093;
  localparam logic [31:0] BOOT_V = 32'h0000_0001;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        acc_err, rst_req;

  always #4 clk = ~clk;

  keyreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .acc_err(acc_err), .rst_req(rst_req)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit m_locked;
  logic [31:0] model [1024];

  function automatic int ref_cls(int a);
    if (a == 'h00C || a == 'h10C || a == 'h25C || a == 'h530) return 2;
    if (a == 'h004 || a == 'h008 || a == 'h60C || a == 'h614) return 3;
    if (a == 0 || (a >= 'h100 && a <= 'h108) || (a >= 'h110 && a <= 'h16C) ||
        (a >= 'h200 && a <= 'h240) || (a >= 'h700 && a <= 'h7D4)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] ref_reset(int a);
    case (a)
      'h100, 'h104, 'h108: return 32'h0001_A008;
      'h10C: return 32'h0000_003F;
      'h154: return 32'h0000_3F03;
      'h25C: return BOOT_V;
      'h530: return ID_V;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one bus operation; called at a negedge, returns at the next negedge
  task automatic access(bit w, int a, logic [31:0] d, string req);
    bit e_err, e_rst, key;
    int c;
    logic [31:0] e_rd;
    c = ref_cls(a);
    key = (a == 'h004) || (a == 'h008);
    e_rst = 1'b0;
    e_rd = 32'h0;
    if (w) e_err = (c == 0) || (c == 2) || (m_locked && a != 0 && !key);
    else   e_err = (c == 0) || (c == 3);
    if (!w) e_rd = (a == 'h00C) ? {31'b0, m_locked} : model[a >> 2];
    bus_wr = w; bus_rd = !w; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (w) begin
      if (!e_err && !key) begin
        model[a >> 2] = (a == 0) ? {31'b0, d[0]} : d;
        e_rst = (a == 'h200) && d[0];
      end
      if (a == 'h008 && d[15:0] == 16'hDF0D) m_locked = 1'b0;
      if (a == 'h004 && d[15:0] == 16'h767B) m_locked = 1'b1;
    end else begin
      chk(req, "rdata", bus_rdata, e_rd);
    end
    chk(req, "acc_err", 32'(acc_err), 32'(e_err));
    chk("R9", "rst_req", 32'(rst_req), 32'(e_rst));
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R8", "idle acc_err", 32'(acc_err), 0);
    chk("R9", "idle rst_req", 32'(rst_req), 0);
  endtask

  initial begin
    int pool [24] = '{'h000, 'h004, 'h008, 'h00C, 'h010, 'h100, 'h104, 'h108,
                      'h10C, 'h110, 'h154, 'h16C, 'h170, 'h200, 'h240, 'h244,
                      'h25C, 'h530, 'h60C, 'h614, 'h700, 'h7D4, 'h7D8, 'hFFC};
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) model[i] = ref_reset(i * 4);
    m_locked = 1'b1;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset rdata", bus_rdata, 0);
    chk("R1", "reset acc_err", 32'(acc_err), 0);
    chk("R1", "reset rst_req", 32'(rst_req), 0);
    // R1 reset values and lock status
    access(0, 'h00C, 0, "R1");
    access(0, 'h100, 0, "R1");
    access(0, 'h108, 0, "R1");
    access(0, 'h10C, 0, "R1");
    access(0, 'h154, 0, "R1");
    access(0, 'h25C, 0, "R1");
    access(0, 'h530, 0, "R1");
    // R4 locked write dropped, R5 scratch accepted with bit 0 only
    access(1, 'h104, 32'h1234_5678, "R4");
    access(0, 'h104, 0, "R4");
    access(1, 'h000, 32'hFFFF_FFFF, "R5");
    access(0, 'h000, 0, "R5");
    access(1, 'h200, 32'h1, "R4");
    access(0, 'h200, 0, "R4");
    // R2 near-miss then correct unlock key
    access(1, 'h008, 32'h0000_DF0C, "R2");
    access(0, 'h00C, 0, "R2");
    access(1, 'h008, 32'hABCD_DF0D, "R2");
    access(0, 'h00C, 0, "R2");
    access(1, 'h104, 32'hCAFE_0001, "R10");
    access(0, 'h104, 0, "R10");
    access(1, 'h000, 32'h0000_0002, "R5");
    access(0, 'h000, 0, "R5");
    // R9 soft reset pulse, one cycle wide; write of 0 gives none
    access(1, 'h200, 32'h0000_0003, "R9");
    idle_chk();
    access(0, 'h200, 0, "R9");
    access(1, 'h200, 32'h0000_0000, "R9");
    // R6 read-only writes ignored, write-only reads flagged
    access(1, 'h530, 32'hFFFF_FFFF, "R6");
    access(0, 'h530, 0, "R6");
    access(1, 'h00C, 32'h0, "R6");
    access(0, 'h00C, 0, "R6");
    access(1, 'h60C, 32'h55AA_55AA, "R6");
    access(0, 'h60C, 0, "R6");
    access(0, 'h004, 0, "R6");
    // R7 unmapped
    access(1, 'hFFC, 32'hDEAD_BEEF, "R7");
    access(0, 'hFFC, 0, "R7");
    access(0, 'h244, 0, "R7");
    // R3 near-miss then correct lock key
    access(1, 'h004, 32'h0000_767A, "R3");
    access(0, 'h00C, 0, "R3");
    access(1, 'h004, 32'h0000_767B, "R3");
    access(0, 'h00C, 0, "R3");
    access(1, 'h700, 32'h1, "R4");
    access(0, 'h700, 0, "R4");
    idle_chk();
    // R10 random mix
    for (int n = 0; n < 4000; n++) begin
      int sel, a;
      logic [31:0] d;
      sel = int'($urandom_range(0, 99));
      a = pool[$urandom_range(0, 23)];
      d = $urandom();
      if (sel < 5)       access(1, 'h008, {d[31:16], 16'hDF0D}, "R2");
      else if (sel < 10) access(1, 'h004, {d[31:16], 16'h767B}, "R3");
      else if (sel < 55) access(1, a, d, "R10");
      else               access(0, a, 0, "R10");
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule